// File: doc/BRIEF.md
# Embedded Program and Erase Sequencer with Erase Suspend

This block runs the self-timed program and erase algorithms of a byte-wide, sector-organised flash behavioural model. A command decoder hands it finished commands: program a byte, erase the whole array, erase a chosen set of sectors, suspend an erase, and resume an erase. The sequencer then works through the operation alone. A program applies timed pulses and verifies them. An erase first writes zero to every byte in the targeted sectors. It then applies fixed-length erase pulses, each followed by a verify sweep, until the region reads erased or a pulse budget runs out. Time is counted in clock cycles, and the array is a small sector-split memory held in registers.

While an operation runs, a host read returns a status byte instead of array data. The top bit of that byte is the complement of the top bit of the data being written. Another bit flips on every status read. A sector erase can be parked at a step boundary. While it is parked, the host can read, and program bytes in, sectors outside the erase set, and can then resume the erase. Sectors flagged in the protect vector are never altered.

Commands enter through a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops only while a byte program runs. The host must hold the command stable until it is taken. A command that is taken but is not legal in the current state is dropped without effect. Reads are a plain single-cycle request, and the answer comes one cycle later.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `suspended` and `err` are low, `cmd_ready` is high, and every byte reads FFh.
- R2: `cmd_op` code 1 programs `cmd_data` at `cmd_addr`. The stored byte becomes the old byte AND the new data. `busy` is high and `cmd_ready` is low until the byte is verified.
- R3: The sector of an address is its top log2(NSECT) bits. A program or erase aimed at a sector whose `protect` bit is set leaves it unchanged, and a program to such a sector does not raise `busy`.
- R4: A read that returns status gives bit 7 = NOT of bit 7 of the program data (0 during an erase), bit 6 = a toggle that starts at 0 after reset and flips after every status read, and bits 5..0 = 0. Every read made while `busy` is high returns status.
- R5: Code 3 erases every unprotected sector whose bit is set in `cmd_sect` (bit i = sector i) to FFh, and leaves all other sectors unchanged.
- R6: Code 2 erases every unprotected sector. A suspend (code 4) given during a whole-array erase is ignored.
- R7: A suspend given during a sector erase raises `suspended` and drops `busy` at the next step boundary. While suspended, reads outside the erase set return array data, and reads inside it return status.
- R8: While suspended, a program to an unprotected sector outside the erase set runs and returns to the suspended state. A program to a sector inside the erase set is ignored.
- R9: Resume (code 5) continues the parked erase to completion, after which the whole erase set reads FFh.
- R10: During an erase that is not suspended, every command except suspend is ignored.
- R11: If the erase verify still fails after MAX_PULSES pulses, `err` goes high, the operation ends with `busy` low, and `err` stays high until reset.
- R12: `rd_vld` pulses one cycle after `rd_en`. A read issued in the first cycle that `busy` is low after completion returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | 1 program, 2 array erase, 3 sector erase, 4 suspend, 5 resume |
| cmd_addr | input | AW | Program address |
| cmd_data | input | 8 | Program data |
| cmd_sect | input | NSECT | Sector set for a sector erase |
| protect | input | NSECT | Per-sector write protection |
| rd_en | input | 1 | Host read request |
| rd_addr | input | AW | Host read address |
| rd_vld | output | 1 | Read answer valid |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Embedded operation running |
| suspended | output | 1 | Sector erase parked |
| err | output | 1 | Sticky pulse-budget overrun |

## Verification
The bench goes after the AND rule when a byte is programmed twice. A design that overwrote the byte would read back the second value instead of the combined one. It reads status during a program and during an erase, and keeps its own model of the toggle, so a toggle that stuck or a wrong polarity on bit 7 shows up at once. While an erase is parked, it reads a byte outside the erase set and one inside it, and programs a byte on each side. A design that leaked array data from an erasing sector, or that accepted a program into one, would return the wrong byte. A second instance needs more pulses than its budget allows, which proves that `err` is raised and stays high across a later program.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SPROG
  } st_e;

  typedef enum logic [1:0] {
    PH_PRE,
    PH_PULSE,
    PH_VER
  } ph_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] eaddr,
  output logic [7:0]    edata,
  input  logic [AW-1:0] haddr,
  output logic [7:0]    hdata
);
  import flash_seq_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED_BYTE;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign edata = cells[eaddr];
  assign hdata = cells[haddr];

endmodule

// File: rtl/flash_status.sv
module flash_status #(
  parameter int NSECT = 8,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             op_busy,
  input  logic             op_susp,
  input  logic [NSECT-1:0] tgt,
  input  logic             poll,
  input  logic [7:0]       hdata,
  output logic             rd_vld,
  output logic [7:0]       rd_data
);
  localparam int SW = $clog2(NSECT);

  logic tog;
  logic sel;
  logic [SW-1:0] rd_sect;

  assign rd_sect = rd_addr[AW-1 -: SW];
  assign sel     = op_busy || (op_susp && tgt[rd_sect]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= 8'h00;
      tog     <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_data <= sel ? {poll, tog, 6'b0} : hdata;
        if (sel) tog <= ~tog;
      end
    end
  end

endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
  parameter int NSECT      = 8,
  parameter int AW         = 7,
  parameter int PGM_PULSE  = 3,
  parameter int ERS_PULSE  = 6,
  parameter int MAX_PULSES = 4,
  parameter int ERS_NEED   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [7:0]       cmd_data,
  input  logic [NSECT-1:0] cmd_sect,
  input  logic [NSECT-1:0] protect,
  output logic             busy,
  output logic             suspended,
  output logic             err,
  output logic [NSECT-1:0] tgt,
  output logic             poll,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic [AW-1:0]    eaddr,
  input  logic [7:0]       edata
);
  import flash_seq_pkg::*;

  localparam int SW   = $clog2(NSECT);
  localparam int TMAX = (PGM_PULSE > ERS_PULSE) ? PGM_PULSE : ERS_PULSE;
  localparam int TW   = $clog2(TMAX) + 1;
  localparam int PCW  = $clog2(MAX_PULSES + ERS_NEED + 1);

  st_e             st;
  ph_e             ph;
  logic [AW-1:0]   idx;
  logic [TW-1:0]   tmr;
  logic [PCW-1:0]  pulses;
  logic [PCW-1:0]  tries;
  logic [AW-1:0]   p_addr;
  logic [7:0]      p_data;
  logic            p_ver;
  logic            chip;
  logic            susp_pend;

  function automatic logic [SW-1:0] sect_of(input logic [AW-1:0] a);
    return a[AW-1 -: SW];
  endfunction

  logic             acc;
  op_e              op;
  logic             cmd_prot;
  logic             cmd_in_tgt;
  logic [NSECT-1:0] sect_mask;
  logic [NSECT-1:0] chip_mask;
  logic             idx_in;
  logic             idx_last;
  logic             step_ok;
  logic             prog_st;
  logic             pgm_end;
  logic             ers_end;
  logic             ver_done;

  assign op         = op_e'(cmd_op);
  assign prog_st    = (st == ST_PROG) || (st == ST_SPROG);
  assign cmd_ready  = !prog_st;
  assign acc        = cmd_valid && cmd_ready;
  assign busy       = prog_st || (st == ST_ERASE);
  assign suspended  = (st == ST_SUSP);
  assign cmd_prot   = protect[sect_of(cmd_addr)];
  assign cmd_in_tgt = tgt[sect_of(cmd_addr)];
  assign sect_mask  = cmd_sect & ~protect;
  assign chip_mask  = ~protect;
  assign idx_in     = tgt[sect_of(idx)];
  assign idx_last   = &idx;
  assign step_ok    = !(susp_pend && (ph != PH_PULSE));
  assign pgm_end    = (tmr == TW'(PGM_PULSE - 1));
  assign ers_end    = (tmr == TW'(ERS_PULSE - 1));
  assign ver_done   = (pulses >= PCW'(ERS_NEED));
  assign poll       = prog_st ? ~p_data[7] : ~ERASED_BYTE[7];
  assign eaddr      = prog_st ? p_addr : idx;

  // write port: one source per phase
  always_comb begin
    we    = 1'b0;
    waddr = idx;
    wdata = 8'h00;
    if (prog_st) begin
      we    = pgm_end && !p_ver;
      waddr = p_addr;
      wdata = edata & p_data;
    end else if (st == ST_ERASE && step_ok) begin
      if (ph == PH_PRE) begin
        we    = idx_in;
        wdata = 8'h00;
      end else if (ph == PH_VER) begin
        we    = idx_in && ver_done;
        wdata = ERASED_BYTE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_PRE;
      idx       <= '0;
      tmr       <= '0;
      pulses    <= '0;
      tries     <= '0;
      p_addr    <= '0;
      p_data    <= 8'h00;
      p_ver     <= 1'b0;
      chip      <= 1'b0;
      susp_pend <= 1'b0;
      tgt       <= '0;
      err       <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (acc) begin
            if (op == OP_PROG && !cmd_prot) begin
              st     <= ST_PROG;
              p_addr <= cmd_addr;
              p_data <= cmd_data;
              tmr    <= '0;
              tries  <= '0;
              p_ver  <= 1'b0;
            end else if ((op == OP_CHIP && |chip_mask) ||
                         (op == OP_SECT && |sect_mask)) begin
              st        <= ST_ERASE;
              tgt       <= (op == OP_CHIP) ? chip_mask : sect_mask;
              chip      <= (op == OP_CHIP);
              ph        <= PH_PRE;
              idx       <= '0;
              tmr       <= '0;
              pulses    <= '0;
              susp_pend <= 1'b0;
            end
          end
        end

        ST_PROG, ST_SPROG: begin
          if (!p_ver) begin
            if (pgm_end) p_ver <= 1'b1;
            else         tmr   <= tmr + 1'b1;
          end else begin
            p_ver <= 1'b0;
            tmr   <= '0;
            if ((edata & ~p_data) == 8'h00) begin
              st <= (st == ST_PROG) ? ST_IDLE : ST_SUSP;
            end else if (tries == PCW'(MAX_PULSES - 1)) begin
              err <= 1'b1;
              st  <= (st == ST_PROG) ? ST_IDLE : ST_SUSP;
            end else begin
              tries <= tries + 1'b1;
            end
          end
        end

        ST_ERASE: begin
          if (acc && op == OP_SUSP && !chip) susp_pend <= 1'b1;
          if (!step_ok) begin
            st <= ST_SUSP;
          end else begin
            unique case (ph)
              PH_PRE: begin
                idx <= idx + 1'b1;
                if (idx_last) begin
                  ph  <= PH_PULSE;
                  tmr <= '0;
                end
              end
              PH_PULSE: begin
                if (ers_end) begin
                  pulses <= pulses + 1'b1;
                  ph     <= PH_VER;
                  idx    <= '0;
                  tmr    <= '0;
                end else begin
                  tmr <= tmr + 1'b1;
                end
              end
              PH_VER: begin
                if (idx_in && !ver_done) begin
                  if (pulses >= PCW'(MAX_PULSES)) begin
                    err <= 1'b1;
                    st  <= ST_IDLE;
                  end else begin
                    ph  <= PH_PULSE;
                    tmr <= '0;
                  end
                end else begin
                  idx <= idx + 1'b1;
                  if (idx_last) st <= ST_IDLE;
                end
              end
              default: ph <= PH_PRE;
            endcase
          end
        end

        ST_SUSP: begin
          if (acc) begin
            if (op == OP_PROG && !cmd_prot && !cmd_in_tgt) begin
              st     <= ST_SPROG;
              p_addr <= cmd_addr;
              p_data <= cmd_data;
              tmr    <= '0;
              tries  <= '0;
              p_ver  <= 1'b0;
            end else if (op == OP_RESUME) begin
              st        <= ST_ERASE;
              susp_pend <= 1'b0;
            end
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int NSECT      = 8,
  parameter int SECT_AW    = 4,
  parameter int PGM_PULSE  = 3,
  parameter int ERS_PULSE  = 6,
  parameter int MAX_PULSES = 4,
  parameter int ERS_NEED   = 2,
  localparam int AW        = $clog2(NSECT) + SECT_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [7:0]       cmd_data,
  input  logic [NSECT-1:0] cmd_sect,
  input  logic [NSECT-1:0] protect,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_vld,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             suspended,
  output logic             err
);

  logic [NSECT-1:0] tgt;
  logic             poll;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [7:0]       wdata;
  logic [AW-1:0]    eaddr;
  logic [7:0]       edata;
  logic [7:0]       hdata;

  flash_engine #(
    .NSECT(NSECT), .AW(AW), .PGM_PULSE(PGM_PULSE), .ERS_PULSE(ERS_PULSE),
    .MAX_PULSES(MAX_PULSES), .ERS_NEED(ERS_NEED)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sect(cmd_sect),
    .protect(protect), .busy(busy), .suspended(suspended), .err(err),
    .tgt(tgt), .poll(poll), .we(we), .waddr(waddr), .wdata(wdata),
    .eaddr(eaddr), .edata(edata)
  );

  flash_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .eaddr(eaddr), .edata(edata), .haddr(rd_addr), .hdata(hdata)
  );

  flash_status #(.NSECT(NSECT), .AW(AW)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .op_busy(busy), .op_susp(suspended), .tgt(tgt), .poll(poll),
    .hdata(hdata), .rd_vld(rd_vld), .rd_data(rd_data)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int NSECT = 8,
  parameter int AW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [AW-1:0]    cmd_addr,
  input logic [NSECT-1:0] protect,
  input logic             rd_en,
  input logic             rd_vld,
  input logic [7:0]       rd_data,
  input logic             busy,
  input logic             suspended,
  input logic             err
);
  localparam int SW = $clog2(NSECT);

  logic st_pend;
  always_ff @(posedge clk) begin
    if (!rst_n) st_pend <= 1'b0;
    else        st_pend <= rd_en && busy;
  end

  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> busy);

  // R3
  prot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1 && !busy && !suspended &&
     protect[cmd_addr[AW-1 -: SW]]) |=> !busy);

  // R4
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && st_pend) |-> (rd_data[5:0] == 6'b0));

  // R7
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(busy));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R12
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

endmodule

bind flash_seq flash_seq_chk #(.NSECT(NSECT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .protect(protect), .rd_en(rd_en),
  .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy), .suspended(suspended),
  .err(err)
);

// File: tb/test_flash_seq.sv
module test_flash_seq;
  import flash_seq_pkg::*;

  localparam int PERIOD = 10;
  localparam int NSECT  = 8;
  localparam int AW     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic             m_valid = 1'b0, b_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic [AW-1:0]    cmd_addr = '0;
  logic [7:0]       cmd_data = 8'h00;
  logic [NSECT-1:0] cmd_sect = '0;
  logic [NSECT-1:0] protect = '0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0;

  logic m_ready, m_rd_vld, m_busy, m_susp, m_err;
  logic [7:0] m_rd_data;
  logic b_ready, b_rd_vld, b_busy, b_susp, b_err;
  logic [7:0] b_rd_data;

  flash_seq i_flash_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(m_valid), .cmd_ready(m_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_sect(cmd_sect), .protect(protect), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_vld(m_rd_vld), .rd_data(m_rd_data), .busy(m_busy),
    .suspended(m_susp), .err(m_err)
  );

  flash_seq #(.ERS_NEED(6)) i_flash_seq_bad (
    .clk(clk), .rst_n(rst_n), .cmd_valid(b_valid), .cmd_ready(b_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_sect(cmd_sect), .protect(protect), .rd_en(1'b0), .rd_addr(rd_addr),
    .rd_vld(b_rd_vld), .rd_data(b_rd_data), .busy(b_busy),
    .suspended(b_susp), .err(b_err)
  );

  int checks = 0;
  int errors = 0;
  logic tog_m = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st_exp(input logic pbit);
    logic [7:0] v;
    v = {pbit, tog_m, 6'b0};
    tog_m = ~tog_m;
    return v;
  endfunction

  // monitor: pops one expected answer per read response
  always @(negedge clk) begin
    if (m_rd_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected rd_vld", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(m_rd_data == e, t, m_rd_data, e);
      end
    end
  end

  task automatic cmd(input bit bad, input op_e op, input int a, input int d, input int s);
    @(negedge clk);
    cmd_op   = op;
    cmd_addr = AW'(a);
    cmd_data = 8'(d);
    cmd_sect = NSECT'(s);
    if (bad) b_valid = 1'b1; else m_valid = 1'b1;
    @(negedge clk);
    m_valid = 1'b0;
    b_valid = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle(input bit bad, input string tag);
    int n = 0;
    while ((bad ? b_busy : m_busy) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, n, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!m_busy && !m_susp && !m_err && m_ready, "R1 reset flags",
        {m_busy, m_susp, m_err, m_ready}, 4'b0001);
    rd(7'h05, 8'hFF, "R1 erased after reset");
    rd(7'h7F, 8'hFF, "R1 erased top byte");

    // R2 program, status read while busy (R4)
    cmd(0, OP_PROG, 7'h12, 8'hA5, 0);
    chk(m_busy && !m_ready, "R2 busy and not ready", {m_busy, m_ready}, 2'b10);
    rd(7'h12, st_exp(1'b0), "R4 status during program A5");
    wait_idle(0, "R2 program finishes");
    rd(7'h12, 8'hA5, "R2 programmed byte");
    cmd(0, OP_PROG, 7'h12, 8'h3C, 0);
    wait_idle(0, "R2 second program finishes");
    rd(7'h12, 8'h24, "R2 AND of old and new");

    // R4 poll bit with data bit7 = 0
    cmd(0, OP_PROG, 7'h30, 8'h7F, 0);
    rd(7'h30, st_exp(1'b1), "R4 status during program 7F");
    wait_idle(0, "R2 third program finishes");
    // R12 read in first idle cycle returns array
    rd(7'h30, 8'h7F, "R12 array data once idle");

    // R3 protected program is ignored
    protect = 8'b0000_0100;
    cmd(0, OP_PROG, 7'h25, 8'h00, 0);
    chk(!m_busy, "R3 protected program not started", m_busy, 0);
    rd(7'h25, 8'hFF, "R3 protected byte unchanged");

    cmd(0, OP_PROG, 7'h45, 8'h11, 0);
    wait_idle(0, "R2 sector4 program finishes");

    // R5 sector erase of sectors 1,2(protected),3
    cmd(0, OP_SECT, 0, 0, 8'b0000_1110);
    chk(m_busy, "R5 erase started", m_busy, 1);
    cmd(0, OP_PROG, 7'h05, 8'h00, 0);
    rd(7'h60, st_exp(1'b0), "R4 status during erase");
    // R7 suspend
    cmd(0, OP_SUSP, 0, 0, 0);
    begin
      int n = 0;
      while (!m_susp && n < 1000) begin @(negedge clk); n++; end
      chk(m_susp && !m_busy, "R7 suspended and not busy", {m_susp, m_busy}, 2'b10);
    end
    rd(7'h45, 8'h11, "R7 array read outside erase set");
    rd(7'h12, st_exp(1'b0), "R7 status read inside erase set");
    // R8 program while suspended
    cmd(0, OP_PROG, 7'h46, 8'h22, 0);
    chk(m_busy, "R8 suspended program runs", m_busy, 1);
    wait_idle(0, "R8 suspended program finishes");
    chk(m_susp, "R8 back to suspended", m_susp, 1);
    rd(7'h46, 8'h22, "R8 byte programmed during suspend");
    cmd(0, OP_PROG, 7'h13, 8'h00, 0);
    chk(!m_busy && m_susp, "R8 program into erase set ignored",
        {m_busy, m_susp}, 2'b01);
    // R9 resume
    cmd(0, OP_RESUME, 0, 0, 0);
    chk(m_busy && !m_susp, "R9 resumed", {m_busy, m_susp}, 2'b10);
    wait_idle(0, "R9 erase completes");
    rd(7'h12, 8'hFF, "R9 sector1 erased");
    rd(7'h30, 8'hFF, "R9 sector3 erased");
    rd(7'h45, 8'h11, "R5 sector4 kept");
    rd(7'h46, 8'h22, "R5 sector4 suspend write kept");
    rd(7'h05, 8'hFF, "R10 program during erase ignored");
    chk(!m_err, "R11 no error on good erase", m_err, 0);

    // R6 chip erase with sector 2 protected
    protect = 8'b0000_0000;
    cmd(0, OP_PROG, 7'h25, 8'h5A, 0);
    wait_idle(0, "R2 sector2 program finishes");
    protect = 8'b0000_0100;
    cmd(0, OP_CHIP, 0, 0, 0);
    cmd(0, OP_SUSP, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(m_busy && !m_susp, "R6 suspend ignored in chip erase", {m_busy, m_susp}, 2'b10);
    wait_idle(0, "R6 chip erase completes");
    rd(7'h25, 8'h5A, "R3 protected sector survives chip erase");
    rd(7'h45, 8'hFF, "R6 sector4 erased");
    rd(7'h46, 8'hFF, "R6 sector4 byte2 erased");

    // R11 pulse budget overrun on the second instance
    protect = 8'b0000_0000;
    cmd(1, OP_SECT, 0, 0, 8'b0000_0001);
    wait_idle(1, "R11 failing erase ends");
    chk(b_err && !b_busy, "R11 error raised", {b_err, b_busy}, 2'b10);
    cmd(1, OP_PROG, 7'h01, 8'h0F, 0);
    wait_idle(1, "R11 later program ends");
    chk(b_err, "R11 error sticky", b_err, 1);
    chk(!m_err, "R11 good instance clean", m_err, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule